// File: doc/BRIEF.md
# Dual-Law Serial Clock Divider

This block derives the serial clock of an SPI shifter from a faster module clock. Two divider laws are offered. The linear law divides the module clock by an even ratio 2*(m+1), where m is an 8-bit field. The power-of-two law divides by 2^(n+1), where n is a 4-bit field. A law-select input chooses which field is in force. The linear law covers ratios from 2 up to 512 in even steps. The power-of-two law reaches much slower rates, down to a divide of 65536.

The shift engine downstream does not use the divided clock as a clock. It uses the strobes produced here. `half_tick` is a one-cycle pulse at each half period of the serial clock. `lead_tick` and `trail_tick` split that pulse by the direction in which the serial clock is about to change. `sclk` is the resulting 50%-duty level, registered and low while idle. Polarity and phase are handled downstream and are not part of this block.

While `run` is low the divider stays idle, and on every clock it captures the three configuration inputs into shadow registers. While `run` is high those shadows are frozen, so a burst always runs at one rate.

Top module: `spi_sclk_divider`

## Requirements
- R1: With `law_lin` = 1 the half period is m+1 module-clock cycles, where m = `lin_m`, so `sclk` has a period of 2*(m+1) cycles.
- R2: With `law_lin` = 0 the half period is 2^n module-clock cycles, where n = `pow_n`, so `sclk` has a period of 2^(n+1) cycles.
- R3: Linear law with m = 0 is the fastest setting: `half_tick` is high in every running cycle and `sclk` toggles on every clock edge.
- R4: The slowest settings are exact. m = 255 gives a period of 512 cycles, and n = 15 gives a period of 65536 cycles. No half period ever exceeds 32768 cycles.
- R5: While running, `half_tick` is high for exactly one cycle at the end of each half period. Counted from the first cycle in which `run` is high, the first pulse falls in cycle H, where H is the half period. `sclk` changes on the clock edge that ends a pulse cycle and at no other edge while running.
- R6: While `run` is low, `half_tick`, `lead_tick` and `trail_tick` are low and `sclk` is driven low on the next edge. Dropping `run` in mid-period and raising it again restarts the pattern from the beginning.
- R7: The configuration inputs are captured only on edges where `run` is low. Changes made while `run` is high have no effect on the running burst. They take effect in the next burst, provided they are held through at least one edge with `run` low.
- R8: `lead_tick` equals `half_tick` while `sclk` is low, which means `sclk` goes high next. `trail_tick` equals `half_tick` while `sclk` is high. The two are never high together.
- R9: During and right after reset, `sclk`, `half_tick`, `lead_tick` and `trail_tick` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | High while a burst is being clocked |
| law_lin | input | 1 | 1 selects the linear law, 0 selects the power-of-two law |
| lin_m | input | 8 | Linear-law field m |
| pow_n | input | 4 | Power-of-two-law field n |
| sclk | output | 1 | 50%-duty serial clock level, low while idle |
| half_tick | output | 1 | One-cycle strobe at each half period |
| lead_tick | output | 1 | Strobe before `sclk` rises |
| trail_tick | output | 1 | Strobe before `sclk` falls |

## Verification
The assertions check on every cycle the properties that can be read locally:
- `sclk` moves only after a strobe, and is forced low when idle.
- The lead and trail strobes point the right way.
- The shadow fields stay frozen during a burst.
- The fastest setting strobes every cycle.
- No gap between strobes exceeds the longest half period.

The exact rate for each field value, the first-pulse position, and the restart after a mid-period stop can only be shown by the bench's scenarios. These scenarios sweep the linear field over its low range and its top values, and the power-of-two field from 0 to 12 and at 15.

// File: rtl/spi_sclk_div_pkg.sv
package spi_sclk_div_pkg;

  // Law selector encoding shared by the blocks and the checker.
  typedef enum logic {
    LAW_POW = 1'b0,
    LAW_LIN = 1'b1
  } div_law_e;

  localparam int DEF_LIN_W = 8;
  localparam int DEF_EXP_W = 4;

  // Counter width needed to hold the largest terminal count 2^(2^EXP_W - 1) - 1.
  function automatic int cnt_width(input int exp_w);
    return (1 << exp_w) - 1;
  endfunction

endpackage

// File: rtl/sdiv_cfg_hold.sv
module sdiv_cfg_hold
  import spi_sclk_div_pkg::*;
#(
  parameter int LIN_W = DEF_LIN_W,
  parameter int EXP_W = DEF_EXP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             law_in,
  input  logic [LIN_W-1:0] lin_in,
  input  logic [EXP_W-1:0] exp_in,
  output div_law_e         law_q,
  output logic [LIN_W-1:0] lin_q,
  output logic [EXP_W-1:0] exp_q
);

  logic cap_en;

  // Shadows follow the inputs only while the divider is idle.
  always_comb begin
    cap_en = ~run;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      law_q <= LAW_POW;
      lin_q <= '0;
      exp_q <= '0;
    end else if (cap_en) begin
      law_q <= div_law_e'(law_in);
      lin_q <= lin_in;
      exp_q <= exp_in;
    end
  end

endmodule

// File: rtl/sdiv_term.sv
module sdiv_term
  import spi_sclk_div_pkg::*;
#(
  parameter int LIN_W = DEF_LIN_W,
  parameter int EXP_W = DEF_EXP_W,
  localparam int CNT_W = cnt_width(EXP_W)
) (
  input  div_law_e         law,
  input  logic [LIN_W-1:0] lin_m,
  input  logic [EXP_W-1:0] pow_n,
  output logic [CNT_W-1:0] term
);

  logic [CNT_W-1:0] pow_term;
  logic [CNT_W-1:0] lin_term;

  // Power-of-two terminal count 2^n - 1: a mask of n ones from the bottom.
  for (genvar i = 0; i < CNT_W; i++) begin : g_pow_mask
    assign pow_term[i] = (EXP_W'(i) < pow_n);
  end

  assign lin_term = {{(CNT_W-LIN_W){1'b0}}, lin_m};

  always_comb begin
    term = (law == LAW_LIN) ? lin_term : pow_term;
  end

endmodule

// File: rtl/sdiv_phase.sv
module sdiv_phase #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] term,
  output logic             sclk,
  output logic             tick,
  output logic             lead,
  output logic             trail
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sclk_q, sclk_d;
  logic             at_end;

  always_comb begin
    at_end = (cnt_q == term);
    cnt_d  = cnt_q;
    sclk_d = sclk_q;
    if (!run) begin
      cnt_d  = '0;
      sclk_d = 1'b0;
    end else if (at_end) begin
      cnt_d  = '0;
      sclk_d = ~sclk_q;
    end else begin
      cnt_d  = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end

  assign tick  = run & at_end;
  assign lead  = tick & ~sclk_q;
  assign trail = tick & sclk_q;
  assign sclk  = sclk_q;

endmodule

// File: rtl/spi_sclk_divider.sv
module spi_sclk_divider
  import spi_sclk_div_pkg::*;
#(
  parameter int LIN_W = DEF_LIN_W,
  parameter int EXP_W = DEF_EXP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             law_lin,
  input  logic [LIN_W-1:0] lin_m,
  input  logic [EXP_W-1:0] pow_n,
  output logic             sclk,
  output logic             half_tick,
  output logic             lead_tick,
  output logic             trail_tick
);

  localparam int CNT_W = cnt_width(EXP_W);

  div_law_e         sh_law;
  logic [LIN_W-1:0] sh_lin;
  logic [EXP_W-1:0] sh_exp;
  logic [CNT_W-1:0] term;

  sdiv_cfg_hold #(.LIN_W(LIN_W), .EXP_W(EXP_W)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .law_in (law_lin),
    .lin_in (lin_m),
    .exp_in (pow_n),
    .law_q  (sh_law),
    .lin_q  (sh_lin),
    .exp_q  (sh_exp)
  );

  sdiv_term #(.LIN_W(LIN_W), .EXP_W(EXP_W)) u_term (
    .law   (sh_law),
    .lin_m (sh_lin),
    .pow_n (sh_exp),
    .term  (term)
  );

  sdiv_phase #(.CNT_W(CNT_W)) u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .term  (term),
    .sclk  (sclk),
    .tick  (half_tick),
    .lead  (lead_tick),
    .trail (trail_tick)
  );

endmodule

// File: rtl/spi_sclk_divider_chk.sv
module spi_sclk_divider_chk
  import spi_sclk_div_pkg::*;
#(
  parameter int LIN_W = DEF_LIN_W,
  parameter int EXP_W = DEF_EXP_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             sclk,
  input logic             half_tick,
  input logic             lead_tick,
  input logic             trail_tick,
  input div_law_e         sh_law,
  input logic [LIN_W-1:0] sh_lin,
  input logic [EXP_W-1:0] sh_exp
);

  localparam int MAX_HALF = 1 << cnt_width(EXP_W);

  int gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                gap <= 0;
    else if (!run || half_tick) gap <= 0;
    else                       gap <= gap + 1;
  end

  assert_idle_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !sclk);

  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !(half_tick || lead_tick || trail_tick));

  assert_tick_toggles_R5: assert property (@(posedge clk) disable iff (!rst_n)
    half_tick |=> sclk != $past(sclk));

  assert_hold_between_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !half_tick) |=> $stable(sclk));

  assert_lead_rises_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lead_tick |=> sclk);

  assert_trail_falls_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trail_tick |=> !sclk);

  assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lead_tick, trail_tick}));

  assert_frozen_cfg_R7: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> $stable({sh_law, sh_lin, sh_exp}));

  assert_fastest_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && sh_law == LAW_LIN && sh_lin == '0) |-> half_tick);

  assert_gap_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> gap < MAX_HALF);

endmodule

bind spi_sclk_divider spi_sclk_divider_chk #(.LIN_W(LIN_W), .EXP_W(EXP_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run        (run),
  .sclk       (sclk),
  .half_tick  (half_tick),
  .lead_tick  (lead_tick),
  .trail_tick (trail_tick),
  .sh_law     (sh_law),
  .sh_lin     (sh_lin),
  .sh_exp     (sh_exp)
);

// File: tb/tb_spi_sclk_divider.sv
`timescale 1ns/1ps
module tb_spi_sclk_divider;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       run;
  logic       law_lin;
  logic [7:0] lin_m;
  logic [3:0] pow_n;
  logic       sclk, half_tick, lead_tick, trail_tick;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  spi_sclk_divider dut (
    .clk(clk), .rst_n(rst_n), .run(run), .law_lin(law_lin),
    .lin_m(lin_m), .pow_n(pow_n), .sclk(sclk), .half_tick(half_tick),
    .lead_tick(lead_tick), .trail_tick(trail_tick)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Idle, load fields, hold one more edge with run low so they are captured.
  task automatic setup(input bit lin, input int m, input int n);
    @(negedge clk);
    run = 1'b0;
    law_lin = lin;
    lin_m = 8'(m);
    pow_n = 4'(n);
    @(negedge clk);
    @(negedge clk);
  endtask

  // Raise run and compare every cycle against the half period h.
  // cycles: how many cycles to observe; poke: cycle at which fields are
  // altered while running (0 = never).
  task automatic burst(input int h, input int cycles, input int poke,
                       input string req);
    int bad_tick = 0, bad_sclk = 0, bad_dir = 0;
    int a_t = 0, e_t = 0, a_s = 0, e_s = 0;
    run = 1'b1;
    for (int c = 1; c <= cycles; c++) begin
      bit et, es;
      #1;
      et = ((c % h) == 0);
      es = (((c - 1) / h) % 2) == 1;
      if (half_tick !== et && bad_tick == 0) begin a_t = half_tick; e_t = et; end
      if (half_tick !== et) bad_tick++;
      if (sclk !== es && bad_sclk == 0) begin a_s = sclk; e_s = es; end
      if (sclk !== es) bad_sclk++;
      if (lead_tick !== (et && !es) || trail_tick !== (et && es)) bad_dir++;
      if (c == poke) begin
        law_lin = 1'b0;
        lin_m = 8'd0;
        pow_n = 4'd0;
      end
      @(negedge clk);
    end
    check(bad_tick == 0, req, $sformatf("half_tick pattern h=%0d", h), a_t, e_t);
    check(bad_sclk == 0, req, $sformatf("sclk pattern h=%0d", h), a_s, e_s);
    check(bad_dir == 0, "R8", $sformatf("lead/trail split h=%0d", h), bad_dir, 0);
  endtask

  task automatic stop_check(input string req);
    run = 1'b0;
    @(negedge clk);
    #1;
    check(sclk == 1'b0 && half_tick == 1'b0 && lead_tick == 1'b0 &&
          trail_tick == 1'b0, req, "idle outputs after stop",
          {sclk, half_tick, lead_tick, trail_tick}, 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    run = 1'b0;
    law_lin = 1'b0;
    lin_m = '0;
    pow_n = '0;
    #23;
    check(sclk == 1'b0 && half_tick == 1'b0, "R9", "outputs in reset",
          {sclk, half_tick}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(sclk == 1'b0 && half_tick == 1'b0 && lead_tick == 1'b0 &&
          trail_tick == 1'b0, "R9", "outputs after reset",
          {sclk, half_tick, lead_tick, trail_tick}, 0);

    // R3: fastest linear setting
    setup(1'b1, 0, 9);
    burst(1, 16, 0, "R3");
    stop_check("R6");

    // R1: linear sweep over low values and the top of the range
    for (int m = 1; m < 32; m++) begin
      setup(1'b1, m, 5);
      burst(m + 1, 2 * (m + 1), 0, "R1");
    end
    setup(1'b1, 127, 0);
    burst(128, 256, 0, "R1");
    setup(1'b1, 254, 0);
    burst(255, 510, 0, "R1");
    // R4: maximum linear divide of 512
    setup(1'b1, 255, 0);
    burst(256, 512, 0, "R4");
    stop_check("R6");

    // R2: power-of-two sweep
    for (int n = 0; n < 13; n++) begin
      setup(1'b0, 200, n);
      burst(1 << n, 2 << n, 0, "R2");
    end
    // R4: slowest power-of-two setting, divide by 65536
    setup(1'b0, 0, 15);
    burst(32768, 65536, 0, "R4");
    stop_check("R6");

    // R7: fields changed mid-burst are ignored, then used next burst
    setup(1'b1, 3, 7);
    burst(4, 8, 3, "R7");
    stop_check("R6");
    @(negedge clk);
    burst(1, 6, 0, "R7");
    stop_check("R6");

    // R6: stop in mid-period with sclk high, then restart from the top
    setup(1'b1, 5, 0);
    burst(6, 8, 0, "R6");
    stop_check("R6");
    burst(6, 12, 0, "R6");
    stop_check("R6");

    // R5: first pulse position with a power-of-two setting
    setup(1'b0, 0, 3);
    burst(8, 32, 0, "R5");
    stop_check("R6");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule